// File: doc/BRIEF.md
# Outbound Window Address Translator

This block maps local-bus addresses that fall inside an outbound aperture onto 64-bit PCIe bus addresses. The aperture is cut into a fixed count of equally sized windows. The window size is chosen at run time as a power-of-two number of megabytes. Each window holds a 64-bit base. The low word of that base also carries an enable bit for the window.

A small register port lets software program the global enable, the size code and every window's base. On the translation side, a request presents one local address per cycle. One cycle later the block returns the bus address together with a hit flag. When translation is off globally, or the selected window is disabled, the request misses and the address passes through unchanged. The block carries no transaction data. It only computes addresses.

Top module: `obwin_translator`

## Requirements
- R1: After reset, every register reads zero, `out_valid` is low and any request misses.
- R2: The register map is as follows. Offset 0x004 holds the global enable in bit 1, and its other bits read zero. Offset 0x030 holds the 3-bit size code in bits [2:0], and its other bits read zero. For window n (0..31), the low base word is at 0x200 + 8n and the high base word is at 0x204 + 8n. Both base words are stored and read back in full, and bit 0 of the low word enables the window.
- R3: A read returns its data on `cfg_rdata` in the cycle after `cfg_re` is sampled, and the data holds until the next read.
- R4: Writes to any offset outside the map are ignored, and reads from such an offset return zero.
- R5: `out_valid` is asserted exactly one cycle after `xl_valid` is sampled high, and is low otherwise.
- R6: The window number is ((`xl_addr` - aperture base) >> (20 + size code)) modulo 32.
- R7: On a hit, `out_addr` is {high word, low word with bits [19+size code:0] cleared} plus the aperture-relative address bits [19+size code:0], and `out_hit` is 1.
- R8: With the global enable clear, every request misses: `out_hit` is 0 and `out_addr` is `xl_addr` zero-extended to 64 bits.
- R9: With the global enable set but bit 0 of the selected window's low word clear, the request misses and passes through in the same way as in R8.
- R10: A new size code takes effect on the next request. With code 7 the windows are 128 MB each, and the window number wraps modulo 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, registered |
| xl_valid | input | 1 | Translation request valid |
| xl_addr | input | 32 | Local address to translate |
| out_valid | output | 1 | Translation result valid |
| out_addr | output | 64 | Translated or passed-through address |
| out_hit | output | 1 | 1 when a window translated the address |

## Verification
The assertions assume that `cfg_we` and `cfg_re` are never raised together. They also assume that registers are not rewritten in the same cycle as a translation request, because the lookup in that cycle uses the values held before the write. The passthrough and low-offset checks look one cycle back, so they assume a request address is only meaningful in the cycle its valid is high. The bench drives every register access and every request between clock edges. It keeps configuration writes and requests in separate cycles, and it uses only addresses whose aperture-relative value it reduces modulo the full 4 GB range.

// File: rtl/obwin_pkg.sv
package obwin_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned OFS_W      = 12;
  localparam int unsigned MB_SHIFT   = 20;
  localparam int unsigned GLB_EN_BIT = 1;
  localparam int unsigned SIZE_W     = 3;
  localparam logic [OFS_W-1:0] OFS_CTRL = 12'h004;
  localparam logic [OFS_W-1:0] OFS_SIZE = 12'h030;
  localparam logic [OFS_W-1:0] OFS_WIN  = 12'h200;
  localparam int unsigned WIN_STRIDE_SH = 3;
endpackage

// File: rtl/obwin_regs.sv
module obwin_regs
  import obwin_pkg::*;
#(
  parameter int unsigned NWIN = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic                        cfg_re,
  input  logic [OFS_W-1:0]            cfg_addr,
  input  logic [REG_W-1:0]            cfg_wdata,
  output logic [REG_W-1:0]            cfg_rdata,
  output logic                        glb_en,
  output logic [SIZE_W-1:0]           size_idx,
  output logic [NWIN-1:0][REG_W-1:0]  win_lo,
  output logic [NWIN-1:0][REG_W-1:0]  win_hi
);
  localparam int unsigned WIN_W   = (NWIN > 1) ? $clog2(NWIN) : 1;
  localparam int unsigned WIN_END = OFS_WIN + (NWIN << WIN_STRIDE_SH);

  logic             in_win;
  logic             is_hi;
  logic [WIN_W-1:0] wsel;
  logic             ctrl_we, size_we;
  logic [NWIN-1:0]  lo_we, hi_we;
  logic [REG_W-1:0] rd_next;
  logic             mapped;

  always_comb begin
    in_win  = (32'(cfg_addr) >= 32'(OFS_WIN)) && (32'(cfg_addr) < WIN_END) &&
              (cfg_addr[1:0] == 2'b00);
    is_hi   = cfg_addr[2];
    wsel    = WIN_W'((cfg_addr - OFS_WIN) >> WIN_STRIDE_SH);
    ctrl_we = cfg_we && (cfg_addr == OFS_CTRL);
    size_we = cfg_we && (cfg_addr == OFS_SIZE);
    mapped  = in_win || (cfg_addr == OFS_CTRL) || (cfg_addr == OFS_SIZE);
    lo_we   = '0;
    hi_we   = '0;
    if (cfg_we && in_win) begin
      if (is_hi) hi_we[wsel] = 1'b1;
      else       lo_we[wsel] = 1'b1;
    end
  end

  always_comb begin
    rd_next = '0;
    if (cfg_addr == OFS_CTRL)      rd_next[GLB_EN_BIT] = glb_en;
    else if (cfg_addr == OFS_SIZE) rd_next[SIZE_W-1:0] = size_idx;
    else if (in_win)               rd_next = is_hi ? win_hi[wsel] : win_lo[wsel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_en    <= 1'b0;
      size_idx  <= '0;
      cfg_rdata <= '0;
    end else begin
      if (ctrl_we) glb_en    <= cfg_wdata[GLB_EN_BIT];
      if (size_we) size_idx  <= cfg_wdata[SIZE_W-1:0];
      if (cfg_re)  cfg_rdata <= rd_next;
    end
  end

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_lo[g] <= '0;
        win_hi[g] <= '0;
      end else begin
        if (lo_we[g]) win_lo[g] <= cfg_wdata;
        if (hi_we[g]) win_hi[g] <= cfg_wdata;
      end
    end
  end

  // R2
  size_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    size_we |=> size_idx == $past(cfg_wdata[SIZE_W-1:0]));
  // R2
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> glb_en == $past(cfg_wdata[GLB_EN_BIT]));
  // R4
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_re && !mapped) |=> cfg_rdata == '0);
  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_re |=> $stable(cfg_rdata));
endmodule

// File: rtl/obwin_lookup.sv
module obwin_lookup
  import obwin_pkg::*;
#(
  parameter int unsigned NWIN      = 32,
  parameter logic [31:0] APER_BASE = 32'h8000_0000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        glb_en,
  input  logic [SIZE_W-1:0]           size_idx,
  input  logic [NWIN-1:0][REG_W-1:0]  win_lo,
  input  logic [NWIN-1:0][REG_W-1:0]  win_hi,
  input  logic                        xl_valid,
  input  logic [31:0]                 xl_addr,
  output logic                        out_valid,
  output logic [63:0]                 out_addr,
  output logic                        out_hit
);
  localparam int unsigned WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1;

  logic [4:0]       shamt;
  logic [31:0]      rel;
  logic [31:0]      wmask;
  logic [WIN_W-1:0] widx;
  logic             hit_nx;
  logic [63:0]      addr_nx;

  always_comb begin
    shamt   = 5'(MB_SHIFT) + {2'b00, size_idx};
    rel     = xl_addr - APER_BASE;
    wmask   = (32'h1 << shamt) - 32'h1;
    widx    = WIN_W'(rel >> shamt);
    hit_nx  = glb_en && win_lo[widx][0];
    addr_nx = hit_nx ? {win_hi[widx], (win_lo[widx] & ~wmask) | (rel & wmask)}
                     : {32'h0, xl_addr};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_addr  <= '0;
    end else begin
      out_valid <= xl_valid;
      if (xl_valid) begin
        out_hit  <= hit_nx;
        out_addr <= addr_nx;
      end
    end
  end

  // R5
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid |=> out_valid);
  // R5
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_valid |=> !out_valid);
  // R8
  miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid |=> (out_hit || out_addr == {32'h0, $past(xl_addr)}));
  // R7
  hit_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid |=> (!out_hit || out_addr[19:0] == $past(rel[19:0])));
  // R8
  hit_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && !glb_en) |=> !out_hit);
endmodule

// File: rtl/obwin_translator.sv
module obwin_translator
  import obwin_pkg::*;
#(
  parameter int unsigned NWIN      = 32,
  parameter logic [31:0] APER_BASE = 32'h8000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_re,
  input  logic [11:0] cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        xl_valid,
  input  logic [31:0] xl_addr,
  output logic        out_valid,
  output logic [63:0] out_addr,
  output logic        out_hit
);
  logic [1:0]                rst_sync;
  logic                      rst_n_i;
  logic                      glb_en;
  logic [SIZE_W-1:0]         size_idx;
  logic [NWIN-1:0][REG_W-1:0] win_lo;
  logic [NWIN-1:0][REG_W-1:0] win_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  obwin_regs #(.NWIN(NWIN)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .cfg_we   (cfg_we),
    .cfg_re   (cfg_re),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .glb_en   (glb_en),
    .size_idx (size_idx),
    .win_lo   (win_lo),
    .win_hi   (win_hi)
  );

  obwin_lookup #(.NWIN(NWIN), .APER_BASE(APER_BASE)) u_lookup (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .glb_en   (glb_en),
    .size_idx (size_idx),
    .win_lo   (win_lo),
    .win_hi   (win_hi),
    .xl_valid (xl_valid),
    .xl_addr  (xl_addr),
    .out_valid(out_valid),
    .out_addr (out_addr),
    .out_hit  (out_hit)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n_i) |-> !out_valid && !out_hit);
endmodule

// File: tb/obwin_translator_bench.sv
module obwin_translator_bench;
  localparam logic [31:0] APER = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_re, xl_valid;
  logic [11:0] cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata, xl_addr;
  logic        out_valid, out_hit;
  logic [63:0] out_addr;

  int checks = 0;
  int errors = 0;

  logic        sh_glb;
  logic [2:0]  sh_size;
  logic [31:0] sh_lo [32];
  logic [31:0] sh_hi [32];

  always #5 clk = ~clk;

  obwin_translator #(.NWIN(32), .APER_BASE(APER)) u_obwin_translator (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_re(cfg_re),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .xl_valid(xl_valid), .xl_addr(xl_addr), .out_valid(out_valid),
    .out_addr(out_addr), .out_hit(out_hit)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 12'h004) sh_glb = d[1];
    if (a == 12'h030) sh_size = d[2:0];
    if (a >= 12'h200 && a < 12'h300 && a[1:0] == 2'b00) begin
      if (a[2]) sh_hi[(a - 12'h200) >> 3] = d;
      else      sh_lo[(a - 12'h200) >> 3] = d;
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_re = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_re = 1'b0;
    d = cfg_rdata;
  endtask

  function automatic logic [64:0] model(input logic [31:0] a);
    int unsigned sh;
    logic [31:0] rel, m;
    int unsigned w;
    sh  = 20 + sh_size;
    rel = a - APER;
    m   = (32'h1 << sh) - 1;
    w   = (rel >> sh) % 32;
    if (sh_glb && sh_lo[w][0])
      return {1'b1, sh_hi[w], (sh_lo[w] & ~m) + (rel & m)};
    return {1'b0, 32'h0, a};
  endfunction

  task automatic xlate(input string req, input logic [31:0] a);
    logic [64:0] e;
    e = model(a);
    @(negedge clk);
    xl_valid = 1'b1; xl_addr = a;
    @(negedge clk);
    xl_valid = 1'b0;
    chk(req, {63'h0, out_valid}, 64'h1);
    chk(req, {63'h0, out_hit}, {63'h0, e[64]});
    chk(req, out_addr, e[63:0]);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 out_valid", {63'h0, out_valid}, 64'h0);
    rd(12'h004, d); chk("R1 ctrl", {32'h0, d}, 64'h0);
    rd(12'h030, d); chk("R1 size", {32'h0, d}, 64'h0);
    rd(12'h208, d); chk("R1 win1 lo", {32'h0, d}, 64'h0);
    xlate("R1 miss after reset", 32'h8012_3456);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, d); chk("R2 ctrl readback", {32'h0, d}, 64'h2);
    wr(12'h004, 32'h0);
    wr(12'h030, 32'hFFFF_FFF5);
    rd(12'h030, d); chk("R2 size readback", {32'h0, d}, 64'h5);
    wr(12'h228, 32'hDEAD_BEEF);
    wr(12'h22C, 32'h0123_4567);
    wr(12'h2F8, 32'hCAFE_F00D);
    rd(12'h228, d); chk("R2 win5 lo", {32'h0, d}, 64'hDEAD_BEEF);
    rd(12'h22C, d); chk("R2 win5 hi", {32'h0, d}, 64'h0123_4567);
    rd(12'h2F8, d); chk("R2 win31 lo", {32'h0, d}, 64'hCAFE_F00D);
    // R3: data holds while no read strobe
    @(negedge clk); @(negedge clk);
    chk("R3 rdata hold", {32'h0, cfg_rdata}, 64'hCAFE_F00D);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    wr(12'h100, 32'h1234_5678);
    wr(12'h300, 32'h1111_1111);
    wr(12'h006, 32'hFFFF_FFFF);
    rd(12'h100, d); chk("R4 read 0x100", {32'h0, d}, 64'h0);
    rd(12'h300, d); chk("R4 read 0x300", {32'h0, d}, 64'h0);
    rd(12'h004, d); chk("R4 ctrl untouched", {32'h0, d}, 64'h0);
    rd(12'h200, d); chk("R4 win0 untouched", {32'h0, d}, 64'h0);
  endtask

  task automatic t_glb_off;
    wr(12'h030, 32'h0);
    wr(12'h218, 32'h1230_0001);
    wr(12'h21C, 32'h0000_000A);
    xlate("R8 global off passthrough", APER + 32'h0030_0456);
  endtask

  task automatic t_basic;
    wr(12'h004, 32'h2);
    xlate("R6 R7 window3 1MB", APER + 32'h0030_0456);
    chk("R7 exact value", out_addr, 64'h0000_000A_1230_0456);
    // R5: no request, no valid
    @(negedge clk);
    chk("R5 idle", {63'h0, out_valid}, 64'h0);
  endtask

  task automatic t_win_off;
    wr(12'h220, 32'h5550_0000);
    wr(12'h224, 32'h7);
    xlate("R9 window4 disabled", APER + 32'h0040_0010);
  endtask

  task automatic t_size;
    wr(12'h030, 32'h3);
    wr(12'h210, 32'hFFFF_FFFF);
    wr(12'h214, 32'h0000_00B0);
    xlate("R10 R7 8MB window2", APER + 32'h017A_BCDE);
    chk("R7 8MB exact", out_addr, 64'h0000_00B0_FFFA_BCDE);
    wr(12'h030, 32'h0);
    xlate("R6 modulo wrap window3", APER + 32'h0230_0ABC);
    wr(12'h030, 32'h7);
    wr(12'h2F8, 32'h4000_0001);
    wr(12'h2FC, 32'h0000_0FFF);
    xlate("R10 128MB window31", APER + 32'hFD55_5555);
    chk("R10 128MB exact", out_addr, 64'h0000_0FFF_4555_5555);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    sh_glb = 1'b0; sh_size = 3'd0;
    for (int i = 0; i < 32; i++) begin sh_lo[i] = '0; sh_hi[i] = '0; end
    cfg_we = 1'b0; cfg_re = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    xl_valid = 1'b0; xl_addr = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_regs;
    t_unmapped;
    t_glb_off;
    t_basic;
    t_win_off;
    t_size;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule